// File: doc/BRIEF.md
# Stack and Subroutine Linkage Sequencer

This block does the stack work and program-counter linkage for an 8-bit processor with a 16-bit address space. It owns the 8-bit stack pointer. It accepts one command at a time: vector fetch, single-byte push, single-byte pull, subroutine call or subroutine return. Each command runs over a few cycles on a byte-wide synchronous memory port. A one-cycle `done` pulse marks the cycle in which the new program counter, stack pointer and pulled byte are valid. The stack lives in page one (addresses 0x0100 to 0x01FF) and grows toward lower addresses. Pointer arithmetic wraps modulo 256, so an access never leaves that page.

A call stores the return address minus one as a little-endian word, and a return adds one to the word it pops. The vector-fetch command reads the start address from 0xFFFC and 0xFFFD. It presets the pointer to 0xFD and, together with `done`, strobes the status preset value 0x34 to the flag register that sits outside this block. Instruction decode and interrupt entry belong to other blocks.

The controller is one state machine with these states. `IDLE` waits for a command. `WR_HI` writes the pushed byte, or the high link byte. `WR_LO` writes the low link byte. `RD_LO` issues the first read. `RD_HI` issues the second read. `RD_END` takes the last read byte. `FINISH` raises `done`. The transitions are:
- IDLE→WR_HI on push or call.
- IDLE→RD_LO on vector fetch, pull or return.
- WR_HI→WR_LO on call, and WR_HI→FINISH on push.
- WR_LO→FINISH.
- RD_LO→RD_END on pull, and RD_LO→RD_HI otherwise.
- RD_HI→RD_END.
- RD_END→FINISH.
- FINISH→IDLE.

Top module: `stk_link_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises: `sp_out` is 0xFD, `pc_out` is 0x0000, `cmd_ready` is 1, `done` is 0, and neither memory strobe is active.
- R2: Command code 0 (vector fetch) reads 0xFFFC and then 0xFFFD. `pc_out` becomes {byte at 0xFFFD, byte at 0xFFFC` … that is, the byte at 0xFFFD is the high byte and the byte at 0xFFFC is the low byte. `sp_out` becomes 0xFD. `status_load` is high with `status_value` = 0x34 in the `done` cycle, which is the 4th cycle after acceptance.
- R3: Command code 1 (push) writes `push_data` once at 0x0100+SP and then lowers SP by one. `done` comes in the 2nd cycle after acceptance.
- R4: Command code 2 (pull) reads once at 0x0100+(SP+1). `pull_data` becomes that byte and SP rises by one. `done` comes in the 3rd cycle.
- R5: Command code 3 (call) computes `pc_in`−1. It writes the high byte of that value at 0x0100+SP and then the low byte at 0x0100+(SP−1). SP drops by two and `pc_out` becomes `call_target`. `done` comes in the 3rd cycle.
- R6: Command code 4 (return) reads the low byte at 0x0100+(SP+1) and then the high byte at 0x0100+(SP+2). SP rises by two and `pc_out` becomes that word plus one, modulo 65536. `done` comes in the 4th cycle.
- R7: All stack pointer arithmetic wraps modulo 256, and every stack access has address high byte 0x01.
- R8: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance through the `done` cycle, and commands presented during that time have no effect.
- R9: Command codes 5, 6 and 7 are ignored. They cause no memory access, no change to SP or `pc_out`, and no `done`, and `cmd_ready` stays high.
- R10: The memory port never raises `mem_wr` and `mem_rd` together. Read data is taken from `mem_rdata` one cycle after the read strobe.
- R11: `done` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code: 0 vector fetch, 1 push, 2 pull, 3 call, 4 return |
| cmd_ready | output | 1 | High while idle; a command is taken when valid and ready |
| push_data | input | 8 | Byte to push |
| pc_in | input | 16 | Current program counter, used by call |
| call_target | input | 16 | Call destination |
| mem_addr | output | 16 | Memory byte address |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata the next cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| pc_out | output | 16 | Program counter produced by vector fetch, call or return |
| pull_data | output | 8 | Last pulled byte |
| sp_out | output | 8 | Stack pointer |
| done | output | 1 | One-cycle completion pulse |
| status_load | output | 1 | Strobe to preset the external flag register |
| status_value | output | 8 | Flag preset value (0x34) |

## Verification
The assertions take the memory as a synchronous device that returns read data exactly one cycle after the strobe. They also take `call_target` as held stable during the cycle in which a call is accepted, and the checks of the pointer and program counter at `done` depend on both of these. The bench memory model follows this one-cycle protocol. The bench changes inputs only on falling edges, so every accepted command sees stable operands. Stimulus includes commands offered while the block is busy and undefined codes, which the assertions must tolerate without any state change.

// File: rtl/stk_link_pkg.sv
package stk_link_pkg;

    typedef enum logic [2:0] {
        OP_VECTOR = 3'd0,
        OP_PUSH   = 3'd1,
        OP_PULL   = 3'd2,
        OP_CALL   = 3'd3,
        OP_RET    = 3'd4
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_END,
        ST_FINISH
    } stk_state_e;

    typedef enum logic [2:0] {
        SP_HOLD,
        SP_DEC1,
        SP_DEC2,
        SP_INC1,
        SP_INC2,
        SP_PRESET
    } sp_adj_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    function automatic logic op_known(input logic [2:0] code);
        return code <= OP_LAST;
    endfunction

endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
    import stk_link_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] SP_RESET = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_adj_e           adj,
    output logic [DATA_W-1:0] sp
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else begin
            unique case (adj)
                SP_HOLD:   sp <= sp;
                SP_DEC1:   sp <= sp - ONE;
                SP_DEC2:   sp <= sp - TWO;
                SP_INC1:   sp <= sp + ONE;
                SP_INC2:   sp <= sp + TWO;
                SP_PRESET: sp <= SP_RESET;
                default:   sp <= sp;
            endcase
        end
    end

    // R7: decrement below zero lands on the top of the page
    assert_sp_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adj == SP_DEC1 && sp == '0) |=> sp == {DATA_W{1'b1}});

    // R7: double increment from the top wraps to one
    assert_sp_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adj == SP_INC2 && sp == {DATA_W{1'b1}}) |=> sp == ONE);

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_link_pkg::*;
#(
    parameter int                       ADDR_W       = 16,
    parameter int                       DATA_W       = 8,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE   = 8'h01,
    parameter logic [ADDR_W-1:0]        RESET_VECTOR = 16'hFFFC
) (
    input  stk_state_e        state,
    input  stk_op_e           op,
    input  logic [DATA_W-1:0] sp,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    logic [DATA_W-1:0] offset;

    always_comb begin
        unique case (state)
            ST_WR_HI: offset = sp;
            ST_WR_LO: offset = sp - ONE;
            ST_RD_LO: offset = sp + ONE;
            ST_RD_HI: offset = sp + TWO;
            default:  offset = sp;
        endcase
    end

    always_comb begin
        if (op == OP_VECTOR && (state == ST_RD_LO || state == ST_RD_HI))
            addr = RESET_VECTOR + ADDR_W'(state == ST_RD_HI);
        else
            addr = {STACK_PAGE, offset};
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_link_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] sp,
    output stk_state_e        state,
    output stk_op_e           op,
    output sp_adj_e           sp_adj,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] pull_data,
    output logic              done,
    output logic              cmd_ready,
    output logic              status_load
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    stk_state_e        st_q, st_d;
    stk_op_e           op_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] pull_q;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && cmd_valid && op_known(cmd_op);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_op == OP_PUSH || cmd_op == OP_CALL) st_d = ST_WR_HI;
                    else                                        st_d = ST_RD_LO;
                end
            end
            ST_WR_HI:  st_d = (op_q == OP_CALL) ? ST_WR_LO : ST_FINISH;
            ST_WR_LO:  st_d = ST_FINISH;
            ST_RD_LO:  st_d = (op_q == OP_PULL) ? ST_RD_END : ST_RD_HI;
            ST_RD_HI:  st_d = ST_RD_END;
            ST_RD_END: st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        mem_wr      = 1'b0;
        mem_rd      = 1'b0;
        mem_wdata   = '0;
        sp_adj      = SP_HOLD;
        done        = 1'b0;
        cmd_ready   = 1'b0;
        status_load = 1'b0;
        unique case (st_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_WR_HI: begin
                mem_wr    = 1'b1;
                mem_wdata = (op_q == OP_PUSH) ? data_q : link_q[ADDR_W-1 -: DATA_W];
                if (op_q == OP_PUSH) sp_adj = SP_DEC1;
            end
            ST_WR_LO: begin
                mem_wr    = 1'b1;
                mem_wdata = link_q[DATA_W-1:0];
                sp_adj    = SP_DEC2;
            end
            ST_RD_LO: mem_rd = 1'b1;
            ST_RD_HI: mem_rd = 1'b1;
            ST_RD_END: begin
                unique case (op_q)
                    OP_PULL:   sp_adj = SP_INC1;
                    OP_RET:    sp_adj = SP_INC2;
                    OP_VECTOR: sp_adj = SP_PRESET;
                    default:   sp_adj = SP_HOLD;
                endcase
            end
            ST_FINISH: begin
                done        = 1'b1;
                status_load = (op_q == OP_VECTOR);
            end
            default: ;
        endcase
    end

    // operand capture and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_VECTOR;
            data_q <= '0;
            link_q <= '0;
            tgt_q  <= '0;
            lo_q   <= '0;
            pc_q   <= '0;
            pull_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= stk_op_e'(cmd_op);
                data_q <= push_data;
                link_q <= pc_in - PC_ONE;
                tgt_q  <= call_target;
            end
            if (st_q == ST_RD_HI) lo_q <= mem_rdata;
            if (st_q == ST_WR_LO) pc_q <= tgt_q;
            if (st_q == ST_RD_END) begin
                unique case (op_q)
                    OP_PULL:   pull_q <= mem_rdata;
                    OP_RET:    pc_q   <= {mem_rdata, lo_q} + PC_ONE;
                    OP_VECTOR: pc_q   <= {mem_rdata, lo_q};
                    default:   ;
                endcase
            end
        end
    end

    assign state     = st_q;
    assign op        = op_q;
    assign pc_out    = pc_q;
    assign pull_data = pull_q;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && op_known(cmd_op)) |=> !cmd_ready);

    assert_ignore_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && !op_known(cmd_op)) |=> cmd_ready);

    assert_push_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_PUSH) |-> sp == $past(sp, 2) - DATA_W'(1));

    assert_call_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_CALL) |-> pc_out == $past(call_target, 3));

    assert_ret_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_RET) |-> sp == $past(sp, 4) + DATA_W'(2));

endmodule

// File: rtl/stk_link_unit.sv
module stk_link_unit
    import stk_link_pkg::*;
#(
    parameter int                 ADDR_W       = 16,
    parameter int                 DATA_W       = 8,
    parameter logic [ADDR_W-1:0]  RESET_VECTOR = 16'hFFFC,
    parameter logic [DATA_W-1:0]  SP_RESET     = 8'hFD,
    parameter logic [DATA_W-1:0]  STATUS_RESET = 8'h34,
    parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] call_target,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] pull_data,
    output logic [DATA_W-1:0] sp_out,
    output logic              done,
    output logic              status_load,
    output logic [DATA_W-1:0] status_value
);

    stk_state_e        state;
    stk_op_e           op;
    sp_adj_e           sp_adj;
    logic [DATA_W-1:0] sp;

    stk_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .push_data   (push_data),
        .pc_in       (pc_in),
        .call_target (call_target),
        .mem_rdata   (mem_rdata),
        .sp          (sp),
        .state       (state),
        .op          (op),
        .sp_adj      (sp_adj),
        .mem_wr      (mem_wr),
        .mem_rd      (mem_rd),
        .mem_wdata   (mem_wdata),
        .pc_out      (pc_out),
        .pull_data   (pull_data),
        .done        (done),
        .cmd_ready   (cmd_ready),
        .status_load (status_load)
    );

    stk_sp_reg #(.DATA_W(DATA_W), .SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .adj   (sp_adj),
        .sp    (sp)
    );

    stk_addr_gen #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .STACK_PAGE   (STACK_PAGE),
        .RESET_VECTOR (RESET_VECTOR)
    ) u_addr (
        .state (state),
        .op    (op),
        .sp    (sp),
        .addr  (mem_addr)
    );

    assign sp_out       = sp;
    assign status_value = STATUS_RESET;

    // R7: writes always land in the stack page
    assert_write_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE);

endmodule

// File: tb/tb_stk_link_unit.sv
module tb_stk_link_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_ready;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [15:0] call_target = 16'h0000;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] pc_out;
    logic [7:0]  pull_data, sp_out;
    logic        done, status_load;
    logic [7:0]  status_value;

    always #2 clk = ~clk;  // 250 MHz

    stk_link_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .push_data(push_data), .pc_in(pc_in),
        .call_target(call_target), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_out(pc_out), .pull_data(pull_data), .sp_out(sp_out), .done(done),
        .status_load(status_load), .status_value(status_value)
    );

    // memory model: stack page plus the two vector bytes, one-cycle reads
    logic [7:0] page [256];
    localparam logic [7:0] VEC_LO = 8'h23;
    localparam logic [7:0] VEC_HI = 8'hC1;

    always @(posedge clk) begin
        if (mem_wr && mem_addr[15:8] == 8'h01) page[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) begin
            if (mem_addr == 16'hFFFC)           mem_rdata <= VEC_LO;
            else if (mem_addr == 16'hFFFD)      mem_rdata <= VEC_HI;
            else if (mem_addr[15:8] == 8'h01)   mem_rdata <= page[mem_addr[7:0]];
            else                                mem_rdata <= 8'h00;
        end
    end

    // access log
    logic [15:0] wr_a [8];
    logic [7:0]  wr_d [8];
    logic [15:0] rd_a [8];
    int wr_n = 0, rd_n = 0;
    int checks = 0, fails = 0;
    logic finished = 1'b0;

    always @(negedge clk) begin
        if (mem_wr && wr_n < 8) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; wr_n++; end
        if (mem_rd && rd_n < 8) begin rd_a[rd_n] = mem_addr; rd_n++; end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] d,
                           input logic [15:0] p, input logic [15:0] t, output int lat);
        @(negedge clk);
        wr_n = 0; rd_n = 0;
        cmd_valid = 1'b1; cmd_op = op; push_data = d; pc_in = p; call_target = t;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // op, data, pc_in, target, exp_pc, exp_sp, exp_pull, latency
    localparam logic [78:0] VEC [9] = '{
        {3'd0, 8'h00, 16'h0000, 16'h0000, 16'hC123, 8'hFD, 8'h00, 4'd4},
        {3'd1, 8'hA5, 16'h0000, 16'h0000, 16'hC123, 8'hFC, 8'h00, 4'd2},
        {3'd1, 8'h5A, 16'h0000, 16'h0000, 16'hC123, 8'hFB, 8'h00, 4'd2},
        {3'd2, 8'h00, 16'h0000, 16'h0000, 16'hC123, 8'hFC, 8'h5A, 4'd3},
        {3'd3, 8'h00, 16'h2000, 16'h3456, 16'h3456, 8'hFA, 8'h00, 4'd3},
        {3'd4, 8'h00, 16'h0000, 16'h0000, 16'h2000, 8'hFC, 8'h00, 4'd4},
        {3'd2, 8'h00, 16'h0000, 16'h0000, 16'h2000, 8'hFD, 8'hA5, 4'd3},
        {3'd3, 8'h00, 16'h0000, 16'hBEEF, 16'hBEEF, 8'hFB, 8'h00, 4'd3},
        {3'd4, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'hFD, 8'h00, 4'd4}
    };

    initial begin
        int lat;
        logic [7:0] s0;
        logic [15:0] p0, lnk;
        for (int i = 0; i < 256; i++) page[i] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sp_out == 8'hFD, "R1 sp", 32'(sp_out), 32'hFD);
        chk(pc_out == 16'h0, "R1 pc", 32'(pc_out), 32'h0);
        chk(cmd_ready && !done && !mem_wr && !mem_rd, "R1 idle", {cmd_ready, done, mem_wr, mem_rd}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 8'hFD && cmd_ready && !done, "R1 after release", 32'(sp_out), 32'hFD);

        // table of commands
        for (int k = 0; k < 9; k++) begin
            logic [78:0] v;
            v = VEC[k];
            s0 = sp_out;
            run_cmd(v[78:76], v[75:68], v[67:52], v[51:36], lat);
            chk(lat == int'(v[3:0]), "R11 latency", 32'(lat), 32'(v[3:0]));
            chk(pc_out == v[35:20], "R2/R5/R6 pc", 32'(pc_out), 32'(v[35:20]));
            chk(sp_out == v[19:12], "R3/R4/R7 sp", 32'(sp_out), 32'(v[19:12]));
            unique case (v[78:76])
                3'd0: begin
                    chk(rd_n == 2 && rd_a[0] == 16'hFFFC && rd_a[1] == 16'hFFFD, "R2 vector reads", 32'(rd_a[0]), 32'hFFFC);
                    chk(status_load && status_value == 8'h34, "R2 status preset", {status_load, status_value}, 32'h134);
                end
                3'd1: chk(wr_n == 1 && wr_a[0] == {8'h01, s0} && wr_d[0] == v[75:68], "R3 push write",
                          {wr_a[0], wr_d[0]}, {8'h01, s0, v[75:68]});
                3'd2: begin
                    chk(rd_n == 1 && rd_a[0] == {8'h01, s0 + 8'd1}, "R4 pull address", 32'(rd_a[0]), {8'h01, s0 + 8'd1});
                    chk(pull_data == v[11:4], "R4 pull data", 32'(pull_data), 32'(v[11:4]));
                end
                3'd3: begin
                    lnk = v[67:52] - 16'd1;
                    chk(wr_n == 2 && wr_a[0] == {8'h01, s0} && wr_d[0] == lnk[15:8], "R5 high link byte",
                        {wr_a[0], wr_d[0]}, {8'h01, s0, lnk[15:8]});
                    chk(wr_a[1] == {8'h01, s0 - 8'd1} && wr_d[1] == lnk[7:0], "R5 low link byte",
                        {wr_a[1], wr_d[1]}, {8'h01, s0 - 8'd1, lnk[7:0]});
                end
                3'd4: chk(rd_n == 2 && rd_a[0] == {8'h01, s0 + 8'd1} && rd_a[1] == {8'h01, s0 + 8'd2},
                          "R6 return reads", {rd_a[0], rd_a[1]}, {8'h01, s0 + 8'd1, 8'h01, s0 + 8'd2});
                default: ;
            endcase
            if (v[78:76] != 3'd0) chk(!status_load, "R2 no status strobe", 32'(status_load), 32'h0);
            @(negedge clk);
            chk(!done && cmd_ready, "R11 single pulse", {done, cmd_ready}, 32'h1);
        end

        // R9: undefined codes ignored
        for (int c = 5; c < 8; c++) begin
            s0 = sp_out; p0 = pc_out;
            @(negedge clk);
            wr_n = 0; rd_n = 0;
            cmd_valid = 1'b1; cmd_op = 3'(c);
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if (done) chk(1'b0, "R9 done on unknown code", 32'h1, 32'h0);
            end
            chk(cmd_ready && wr_n == 0 && rd_n == 0, "R9 no activity", {cmd_ready, wr_n[3:0], rd_n[3:0]}, 32'h100);
            chk(sp_out == s0 && pc_out == p0, "R9 state unchanged", {pc_out, sp_out}, {p0, s0});
        end

        // R8: command offered while busy is dropped
        s0 = sp_out;
        @(negedge clk);
        wr_n = 0; rd_n = 0;
        cmd_valid = 1'b1; cmd_op = 3'd1; push_data = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        chk(!cmd_ready, "R8 busy after accept", 32'(cmd_ready), 32'h0);
        cmd_op = 3'd1; push_data = 8'h99;  // still valid during busy
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done, "R8 push done", 32'(done), 32'h1);
        repeat (3) @(negedge clk);
        chk(wr_n == 1 && sp_out == s0 - 8'd1, "R8 only one push", {wr_n[7:0], sp_out}, {8'd1, s0 - 8'd1});
        run_cmd(3'd2, 8'h00, 16'h0, 16'h0, lat);
        chk(pull_data == 8'h3C && sp_out == s0, "R8 pulled first byte", 32'(pull_data), 32'h3C);

        // R7: wrap of the pointer through zero
        for (int n = 0; n < 253; n++) run_cmd(3'd1, 8'(n), 16'h0, 16'h0, lat);
        chk(sp_out == 8'h00, "R7 sp reaches zero", 32'(sp_out), 32'h00);
        run_cmd(3'd1, 8'h77, 16'h0, 16'h0, lat);
        chk(wr_a[0] == 16'h0100 && sp_out == 8'hFF, "R7 push wraps", {wr_a[0], sp_out}, 32'h0100FF);
        run_cmd(3'd2, 8'h00, 16'h0, 16'h0, lat);
        chk(rd_a[0] == 16'h0100 && pull_data == 8'h77 && sp_out == 8'h00, "R7 pull wraps",
            {rd_a[0], pull_data}, 32'h010077);
        run_cmd(3'd3, 8'h00, 16'h1234, 16'h4000, lat);
        chk(wr_a[0] == 16'h0100 && wr_a[1] == 16'h01FF && sp_out == 8'hFE, "R7 call wraps",
            {wr_a[0], wr_a[1]}, 32'h010001FF);
        run_cmd(3'd4, 8'h00, 16'h0, 16'h0, lat);
        chk(rd_a[0] == 16'h01FF && rd_a[1] == 16'h0100, "R7 return wraps", {rd_a[0], rd_a[1]}, 32'h01FF0100);
        chk(pc_out == 16'h1234 && sp_out == 8'h00, "R6 return after wrap", {pc_out, sp_out}, 32'h123400);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sp_out == 8'hFD && pc_out == 16'h0 && cmd_ready && !done, "R1 second reset",
            {pc_out, sp_out}, 32'h0000FD);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule